// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Converter

This block sits between a 36-bit long-word port and a narrow port whose width is 9, 18 or 36 bits. In one direction it breaks each long word into a short series of narrow beats. In the other it gathers narrow beats back into one long word. Each of the four streams (wide in, narrow out, narrow in, wide out) uses a valid/ready handshake. Everything runs on one clock.

The narrow width and the byte order are configuration. They are captured on every clock while the synchronous reset is high, and they are frozen once reset falls. With big-endian order the most significant piece travels first. With little-endian order the least significant piece travels first. At full 36-bit width there is one beat per long word, so the order setting makes no difference.

Top module: `bus_match_conv`

## Requirements
- R1: Byte mode (`cfg_size`=2'b00) with `cfg_big_endian`=1 splits a long word into four 9-bit beats, bits [35:27] first, then [26:18], then [17:9], then [8:0].
- R2: With `cfg_big_endian`=0 the split order is reversed: bits [8:0] go first and bits [35:27] go last in byte mode, and the same reversal applies in word mode.
- R3: With `cfg_big_endian`=1 the assembler places the first narrow beat in the most significant position of the long word and the last beat in the least significant position.
- R4: With `cfg_big_endian`=0 the first narrow beat lands in the least significant position and the last beat in the most significant position.
- R5: Long mode (`cfg_size`=2'b10 or 2'b11) moves each word unchanged in a single beat in both directions, whatever the endian setting.
- R6: `cfg_size` and `cfg_big_endian` are sampled on every clock while `rst` is high and hold the value from the last reset cycle. Changes made after reset have no effect.
- R7: Word mode (`cfg_size`=2'b01) uses two 18-bit beats, bits [35:18] and [17:0], ordered as described in R1 to R4.
- R8: A new long word is accepted on `wide_in` only when the previous split is finished. `wide_in_ready` stays low while beats remain. The narrow output holds its data stable while it is stalled.
- R9: An assembled word appears on `wide_out` only after its last narrow beat has been taken. It stays valid and stable until it is accepted, and no narrow input is taken while it waits.
- R10: Reset clears both valid outputs and discards any partly split or partly gathered data. The next transfer after reset starts at beat zero.
- R11: Narrow-port bits above the active width read as zero on `nar_out_data` and are ignored on `nar_in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset; configuration is captured while it is high |
| cfg_big_endian | input | 1 | 1 = most significant piece first |
| cfg_size | input | 2 | narrow width: 00 = 9-bit, 01 = 18-bit, 1x = 36-bit |
| wide_in_data | input | 36 | long word to split |
| wide_in_valid | input | 1 | wide_in_data is valid |
| wide_in_ready | output | 1 | splitter can take a long word |
| nar_out_data | output | 36 | narrow beat, low-aligned, upper bits zero |
| nar_out_valid | output | 1 | nar_out_data is valid |
| nar_out_ready | input | 1 | sink takes the narrow beat |
| nar_in_data | input | 36 | narrow beat to gather, low-aligned |
| nar_in_valid | input | 1 | nar_in_data is valid |
| nar_in_ready | output | 1 | assembler can take a beat |
| wide_out_data | output | 36 | assembled long word |
| wide_out_valid | output | 1 | wide_out_data is valid |
| wide_out_ready | input | 1 | sink takes the long word |

## Verification
The assertions assume that a source obeys the handshake and that the configuration is meant to be read only during reset. Nothing in the design constrains the source, so the stall-stability checks cover only the block's own outputs. The stimulus changes the configuration pins freely after reset to show that they are ignored. It puts random values in the unused narrow-input bits, and it drives the ready inputs both randomly and held low so that backpressure occurs on every beat position.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LALT = 2'b11
  } size_e;

  // lanes carried by one narrow beat for a given size code
  function automatic int lanes_per_beat(input size_e s, input int lanes);
    case (s)
      SZ_BYTE: return 1;
      SZ_WORD: return lanes / 2;
      default: return lanes;
    endcase
  endfunction

endpackage

// File: rtl/bmc_cfg.sv
module bmc_cfg
  import bmc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES + 1),
  localparam int BW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          big_end_i,
  input  logic [1:0]    size_i,
  output logic          big_end_o,
  output logic [LW-1:0] lpb_o,
  output logic [BW-1:0] last_o
);

  logic  be_q;
  size_e size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      be_q   <= big_end_i;
      size_q <= size_e'(size_i);
    end
  end

  always_comb begin
    big_end_o = be_q;
    lpb_o     = LW'(lanes_per_beat(size_q, LANES));
    last_o    = BW'(LANES / lanes_per_beat(size_q, LANES) - 1);
  end

  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(be_q) && $stable(size_q)));

endmodule

// File: rtl/bmc_split.sv
module bmc_split #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WIDE = LANE_W * LANES,
  localparam int LW   = $clog2(LANES + 1),
  localparam int BW   = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            big_end,
  input  logic [LW-1:0]   lpb,
  input  logic [BW-1:0]   last_idx,
  input  logic [WIDE-1:0] w_data,
  input  logic            w_valid,
  output logic            w_ready,
  output logic [WIDE-1:0] n_data,
  output logic            n_valid,
  input  logic            n_ready
);

  logic [WIDE-1:0] hold_q;
  logic [BW-1:0]   cnt_q;
  logic [WIDE-1:0] n_data_q;
  logic            n_valid_q;
  logic            at_last;

  function automatic int piece_of(input logic [BW-1:0] beat);
    return big_end ? (int'(last_idx) - int'(beat)) : int'(beat);
  endfunction

  function automatic logic [WIDE-1:0] pick(input logic [WIDE-1:0] src,
                                           input logic [BW-1:0] beat);
    logic [WIDE-1:0] r;
    logic [WIDE-1:0] t;
    int              base;
    r    = '0;
    base = piece_of(beat) * int'(lpb);
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(lpb)) begin
        t = src >> ((base + i) * LANE_W);
        r[i*LANE_W +: LANE_W] = t[LANE_W-1:0];
      end
    end
    return r;
  endfunction

  assign at_last = (cnt_q == last_idx);
  assign w_ready = !n_valid_q || (n_ready && at_last);
  assign n_data  = n_data_q;
  assign n_valid = n_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      cnt_q     <= '0;
      n_data_q  <= '0;
      n_valid_q <= 1'b0;
    end else if (w_valid && w_ready) begin
      hold_q    <= w_data;
      cnt_q     <= '0;
      n_data_q  <= pick(w_data, '0);
      n_valid_q <= 1'b1;
    end else if (n_valid_q && n_ready) begin
      if (at_last) begin
        n_valid_q <= 1'b0;
      end else begin
        cnt_q    <= BW'(cnt_q + 1'b1);
        n_data_q <= pick(hold_q, BW'(cnt_q + 1'b1));
      end
    end
  end

  // R8
  split_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (n_valid && !n_ready) |=> (n_valid && $stable(n_data)));

  // R8
  split_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx);

endmodule

// File: rtl/bmc_merge.sv
module bmc_merge #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WIDE = LANE_W * LANES,
  localparam int LW   = $clog2(LANES + 1),
  localparam int BW   = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            big_end,
  input  logic [LW-1:0]   lpb,
  input  logic [BW-1:0]   last_idx,
  input  logic [WIDE-1:0] n_data,
  input  logic            n_valid,
  output logic            n_ready,
  output logic [WIDE-1:0] w_data,
  output logic            w_valid,
  input  logic            w_ready
);

  localparam logic [WIDE-1:0] LANE_MASK = {{(WIDE-LANE_W){1'b0}}, {LANE_W{1'b1}}};

  logic [WIDE-1:0] acc_q;
  logic [BW-1:0]   cnt_q;
  logic [WIDE-1:0] w_data_q;
  logic            w_valid_q;
  logic [WIDE-1:0] merged;

  function automatic logic [WIDE-1:0] place(input logic [WIDE-1:0] acc,
                                            input logic [WIDE-1:0] nd,
                                            input logic [BW-1:0] beat);
    logic [WIDE-1:0] r;
    logic [WIDE-1:0] lane;
    int              base;
    int              sh;
    r    = acc;
    base = (big_end ? (int'(last_idx) - int'(beat)) : int'(beat)) * int'(lpb);
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(lpb)) begin
        sh   = (base + i) * LANE_W;
        lane = (nd >> (i * LANE_W)) & LANE_MASK;
        r    = (r & ~(LANE_MASK << sh)) | (lane << sh);
      end
    end
    return r;
  endfunction

  assign merged  = place(acc_q, n_data, cnt_q);
  assign n_ready = !w_valid_q || w_ready;
  assign w_data  = w_data_q;
  assign w_valid = w_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      w_data_q  <= '0;
      w_valid_q <= 1'b0;
    end else begin
      if (w_valid_q && w_ready) w_valid_q <= 1'b0;
      if (n_valid && n_ready) begin
        if (cnt_q == last_idx) begin
          w_data_q  <= merged;
          w_valid_q <= 1'b1;
          acc_q     <= '0;
          cnt_q     <= '0;
        end else begin
          acc_q <= merged;
          cnt_q <= BW'(cnt_q + 1'b1);
        end
      end
    end
  end

  // R9
  merge_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !w_ready) |=> (w_valid && $stable(w_data)));

  // R9
  merge_block_chk: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !w_ready) |-> !n_ready);

endmodule

// File: rtl/bus_match_conv.sv
module bus_match_conv #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WIDE = LANE_W * LANES,
  localparam int LW   = $clog2(LANES + 1),
  localparam int BW   = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_big_endian,
  input  logic [1:0]      cfg_size,
  input  logic [WIDE-1:0] wide_in_data,
  input  logic            wide_in_valid,
  output logic            wide_in_ready,
  output logic [WIDE-1:0] nar_out_data,
  output logic            nar_out_valid,
  input  logic            nar_out_ready,
  input  logic [WIDE-1:0] nar_in_data,
  input  logic            nar_in_valid,
  output logic            nar_in_ready,
  output logic [WIDE-1:0] wide_out_data,
  output logic            wide_out_valid,
  input  logic            wide_out_ready
);

  logic          be;
  logic [LW-1:0] lpb;
  logic [BW-1:0] last_idx;

  bmc_cfg #(.LANES(LANES)) u_cfg (
    .clk(clk), .rst(rst),
    .big_end_i(cfg_big_endian), .size_i(cfg_size),
    .big_end_o(be), .lpb_o(lpb), .last_o(last_idx)
  );

  bmc_split #(.LANE_W(LANE_W), .LANES(LANES)) u_split (
    .clk(clk), .rst(rst), .big_end(be), .lpb(lpb), .last_idx(last_idx),
    .w_data(wide_in_data), .w_valid(wide_in_valid), .w_ready(wide_in_ready),
    .n_data(nar_out_data), .n_valid(nar_out_valid), .n_ready(nar_out_ready)
  );

  bmc_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
    .clk(clk), .rst(rst), .big_end(be), .lpb(lpb), .last_idx(last_idx),
    .n_data(nar_in_data), .n_valid(nar_in_valid), .n_ready(nar_in_ready),
    .w_data(wide_out_data), .w_valid(wide_out_valid), .w_ready(wide_out_ready)
  );

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!nar_out_valid && !wide_out_valid));

  // R5
  long_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_in_valid && wide_in_ready && (int'(lpb) == LANES))
      |=> (nar_out_data == $past(wide_in_data)));

endmodule

// File: tb/tb_bus_match_conv.sv
module tb_bus_match_conv;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_endian = 1'b1;
  logic [1:0]  cfg_size = 2'b00;
  logic [35:0] wide_in_data = '0;
  logic        wide_in_valid = 1'b0;
  logic        wide_in_ready;
  logic [35:0] nar_out_data;
  logic        nar_out_valid;
  logic        nar_out_ready = 1'b0;
  logic [35:0] nar_in_data = '0;
  logic        nar_in_valid = 1'b0;
  logic        nar_in_ready;
  logic [35:0] wide_out_data;
  logic        wide_out_valid;
  logic        wide_out_ready = 1'b0;

  always #4 clk = ~clk;

  bus_match_conv dut (.*);

  int checks = 0;
  int errors = 0;
  logic [35:0] exp_n[$];
  logic [35:0] exp_w[$];
  logic [1:0]  cur_sz = 2'b00;
  bit          cur_be = 1'b1;
  string       cur_req = "R1";
  bit          rand_rdy = 1'b1;
  bit          force_nr = 1'b1;
  bit          force_wr = 1'b1;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [1:0] sz);
    return (sz == 2'b00) ? 4 : (sz == 2'b01) ? 2 : 1;
  endfunction

  function automatic logic [35:0] beat_of(input logic [35:0] w, input logic [1:0] sz,
                                          input bit be, input int k);
    int n, pw, idx;
    n   = nbeats(sz);
    pw  = 36 / n;
    idx = be ? (n - 1 - k) : k;
    return (w >> (idx * pw)) & ((36'd1 << pw) - 36'd1);
  endfunction

  // ready drivers, changed 2 ns after the rising edge
  initial forever begin
    @(posedge clk); #2;
    nar_out_ready  = rand_rdy ? ($urandom % 4 != 0) : force_nr;
    wide_out_ready = rand_rdy ? ($urandom % 3 != 0) : force_wr;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (nar_out_valid && nar_out_ready) begin
        if (exp_n.size() == 0) check(1'b0, {cur_req, " unexpected narrow beat"}, nar_out_data, '0);
        else begin
          logic [35:0] e;
          e = exp_n.pop_front();
          check(nar_out_data == e, {cur_req, " narrow out (R11)"}, nar_out_data, e);
        end
      end
      if (wide_out_valid && wide_out_ready) begin
        if (exp_w.size() == 0) check(1'b0, {cur_req, " unexpected long word"}, wide_out_data, '0);
        else begin
          logic [35:0] e;
          e = exp_w.pop_front();
          check(wide_out_data == e, {cur_req, " wide out"}, wide_out_data, e);
        end
      end
    end
  end

  task automatic do_reset(input logic [1:0] sz, input bit be);
    @(posedge clk); #1;
    rst = 1'b1; cfg_size = sz; cfg_big_endian = be;
    wide_in_valid = 1'b0; nar_in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    cur_sz = sz; cur_be = be;
    exp_n.delete(); exp_w.delete();
    @(negedge clk);
    // R10 reset state
    check(!nar_out_valid && !wide_out_valid, "R10 reset valids",
          {34'd0, nar_out_valid, wide_out_valid}, '0);
    check(wide_in_ready && nar_in_ready, "R10 reset readies",
          {34'd0, wide_in_ready, nar_in_ready}, 36'd3);
  endtask

  task automatic send_wide(input logic [35:0] w);
    bit hs;
    for (int k = 0; k < nbeats(cur_sz); k++) exp_n.push_back(beat_of(w, cur_sz, cur_be, k));
    @(posedge clk); #1;
    wide_in_data = w; wide_in_valid = 1'b1;
    do begin @(negedge clk); hs = wide_in_ready; @(posedge clk); #1; end while (!hs);
    wide_in_valid = 1'b0;
    if (nbeats(cur_sz) > 1) begin
      @(negedge clk);
      // R8 no new word while beats remain
      check(!wide_in_ready, "R8 ready low mid-split", {35'd0, wide_in_ready}, '0);
    end
  endtask

  task automatic send_beat(input logic [35:0] d);
    bit hs;
    @(posedge clk); #1;
    nar_in_data = d; nar_in_valid = 1'b1;
    do begin @(negedge clk); hs = nar_in_ready; @(posedge clk); #1; end while (!hs);
    nar_in_valid = 1'b0;
  endtask

  function automatic logic [35:0] noisy(input logic [35:0] b, input logic [1:0] sz);
    logic [35:0] junk, mask;
    junk = {$urandom, $urandom};
    mask = (36'd1 << (36 / nbeats(sz))) - 36'd1;
    return b | (junk & ~mask);  // R11 upper bits must be ignored
  endfunction

  task automatic send_seq(input logic [35:0] w);
    exp_w.push_back(w);
    for (int k = 0; k < nbeats(cur_sz); k++) send_beat(noisy(beat_of(w, cur_sz, cur_be, k), cur_sz));
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_n.size() != 0 || exp_w.size() != 0) && t < 3000) begin
      @(negedge clk); t++;
    end
    check(exp_n.size() == 0 && exp_w.size() == 0, {cur_req, " drain"},
          36'(exp_n.size() + exp_w.size()), '0);
  endtask

  task automatic traffic(input int n);
    fork
      for (int i = 0; i < n; i++) send_wide({$urandom, $urandom});
      for (int i = 0; i < n; i++) send_seq({$urandom, $urandom});
    join
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 / R3 byte big-endian, with fixed directed word
    cur_req = "R1 R3";
    do_reset(2'b00, 1'b1);
    send_wide(36'h1_2345_6789);
    send_seq(36'h9_8765_4321);
    traffic(10);
    // R2 / R4 byte little-endian
    cur_req = "R2 R4";
    do_reset(2'b00, 1'b0);
    traffic(10);
    // R7 word mode both orders
    cur_req = "R7 big";
    do_reset(2'b01, 1'b1);
    traffic(8);
    cur_req = "R7 little";
    do_reset(2'b01, 1'b0);
    traffic(8);
    // R5 long mode, both endian settings and the alternate code
    cur_req = "R5 be1";
    do_reset(2'b10, 1'b1);
    traffic(6);
    cur_req = "R5 be0";
    do_reset(2'b11, 1'b0);
    traffic(6);
    // R6 pins changed after reset are ignored
    cur_req = "R6";
    do_reset(2'b00, 1'b1);
    @(posedge clk); #1;
    cfg_size = 2'b01; cfg_big_endian = 1'b0;
    traffic(6);
    // R9 output only after last beat, held under backpressure
    cur_req = "R9";
    rand_rdy = 1'b0; force_wr = 1'b0; force_nr = 1'b1;
    exp_w.push_back(36'hA_BCDE_F012);
    for (int k = 0; k < 3; k++) send_beat(beat_of(36'hA_BCDE_F012, 2'b00, 1'b1, k));
    @(negedge clk);
    check(!wide_out_valid, "R9 no word before last beat", {35'd0, wide_out_valid}, '0);
    send_beat(beat_of(36'hA_BCDE_F012, 2'b00, 1'b1, 3));
    @(negedge clk);
    check(wide_out_valid && wide_out_data == 36'hA_BCDE_F012, "R9 word after last beat",
          wide_out_data, 36'hA_BCDE_F012);
    repeat (3) @(negedge clk);
    check(wide_out_valid && wide_out_data == 36'hA_BCDE_F012, "R9 held while stalled",
          wide_out_data, 36'hA_BCDE_F012);
    check(!nar_in_ready, "R9 input blocked while stalled", {35'd0, nar_in_ready}, '0);
    force_wr = 1'b1;
    drain();
    // R10 reset mid-sequence
    cur_req = "R10";
    force_nr = 1'b0;
    send_wide(36'h5_5555_AAAA);
    send_beat(36'h1FF);
    send_beat(36'h0AA);
    do_reset(2'b00, 1'b1);
    rand_rdy = 1'b1;
    send_seq(36'h3_0F0F_1234);
    send_wide(36'h7_1357_9BDF);
    drain();
    traffic(4);
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule